// File: doc/BRIEF.md
# Event interrupt status controller

This block turns the per-channel event pulses of a timer into interrupt state. Each event source owns one raw status bit. The raw bit is set by a hardware event or by a software set write. It is cleared by a software clear write or by an access side effect: writing a new compare value clears the compare-channel bit, and reading the captured value clears the capture-channel bit. An enable mask is kept next to the raw status. Software can load the mask whole, or change single bits through separate write-one-to-set and write-one-to-clear strobes.

The block outputs the raw status and the mask as registers. From them it forms the masked status, one combined interrupt line, and a pending code that names the lowest-numbered enabled pending source. Every input is a single-cycle strobe that carries its data in the same cycle. No data stream crosses the edge of the block, so there is no valid/ready handshake and no back-pressure: each strobe takes effect at the next rising clock edge, and the block never stalls. Bus decoding and the timer itself sit outside.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, raw status, mask, masked status, `irq_o` and `pend_idx_o` are all zero.
- R2: An `ev_pulse` bit set in a cycle makes the matching raw bit 1 after the next clock edge. This holds even when a software clear or a side-effect clear targets that bit in the same cycle.
- R3: With `isr_set_wr` high, each 1 in `isr_set_data` sets the matching raw bit, and each 0 leaves its bit unchanged. A software set beats any clear of the same bit in the same cycle.
- R4: With `isr_clr_wr` high, each 1 in `isr_clr_data` clears the matching raw bit, unless an event or a set hits that bit in the same cycle. Each 0 leaves its bit unchanged.
- R5: A `cmp_wr` strobe clears raw bit 0, the compare channel, and leaves bit 1 unchanged. A `cap_rd` strobe clears raw bit 1, the capture channel, and leaves bit 0 unchanged. Both obey the priority given in R2 and R3.
- R6: `masked_o` equals `raw_o & mask_o`. A mask bit of 1 enables its source. `irq_o` is 1 exactly when any bit of `masked_o` is 1.
- R7: A `mask_wr` strobe replaces the whole mask with `mask_wdata` at the next clock edge.
- R8: With `mask_set_wr` high, each 1 in `mask_set_data` sets its mask bit. With `mask_clr_wr` high, each 1 in `mask_clr_data` clears its mask bit. Zeros have no effect. In a single cycle the direct load is applied first, then the clear, then the set, so a set beats a clear of the same bit.
- R9: `pend_idx_o` is 1 when masked bit 0 is pending. It is 2 when only masked bit 1 is pending, and 0 when nothing is pending. In general it is the lowest pending bit number plus one, so bit 0 has priority.
- R10: With no strobe and no event in a cycle, the raw status and the mask keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | N_EV | One-cycle hardware event per source |
| mask_wr | input | 1 | Direct mask load strobe |
| mask_wdata | input | N_EV | Value for the direct mask load |
| mask_set_wr | input | 1 | Mask write-one-to-set strobe |
| mask_set_data | input | N_EV | Mask bits to set |
| mask_clr_wr | input | 1 | Mask write-one-to-clear strobe |
| mask_clr_data | input | N_EV | Mask bits to clear |
| isr_set_wr | input | 1 | Raw status write-one-to-set strobe |
| isr_set_data | input | N_EV | Raw bits to set |
| isr_clr_wr | input | 1 | Raw status write-one-to-clear strobe |
| isr_clr_data | input | N_EV | Raw bits to clear |
| cmp_wr | input | 1 | A new compare value was written (clears bit 0) |
| cap_rd | input | 1 | The capture value was read (clears bit 1) |
| raw_o | output | N_EV | Raw status |
| mask_o | output | N_EV | Enable mask |
| masked_o | output | N_EV | Raw status AND mask |
| irq_o | output | 1 | Combined interrupt line |
| pend_idx_o | output | IDX_W | Lowest pending enabled source plus one, 0 when none |

## Verification
The hardest situations to reach from the ports are same-cycle collisions. Examples are an event landing together with a software clear and a side-effect clear, or a direct mask load that meets set and clear strobes on the same bit. Normal software traffic almost never lines these up. The stimulus therefore loads each of the four possible starting states, then applies every combination of event, set, clear, compare-write and capture-read strobes and their data. It repeats this sweep for the three mask paths from every starting mask. After each step it compares all outputs with values computed from the priority rules.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned DEF_N_EV    = 2;
  localparam int unsigned DEF_CMP_BIT = 0;
  localparam int unsigned DEF_CAP_BIT = 1;

  // Width that holds codes 0..n (0 = nothing pending)
  function automatic int unsigned code_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/irq_raw_bit.sv
module irq_raw_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_ev,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic side_clr,
  output logic q
);

  logic set_any;
  logic clr_any;

  // Any set source beats any clear source
  assign set_any = hw_ev | sw_set;
  assign clr_any = sw_clr | side_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (set_any) begin
      q <= 1'b1;
    end else if (clr_any) begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N_EV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [N_EV-1:0] ld_val,
  input  logic            set_en,
  input  logic [N_EV-1:0] set_val,
  input  logic            clr_en,
  input  logic [N_EV-1:0] clr_val,
  output logic [N_EV-1:0] q
);

  logic [N_EV-1:0] base;
  logic [N_EV-1:0] set_bits;
  logic [N_EV-1:0] clr_bits;
  logic [N_EV-1:0] nxt;

  always_comb begin
    base     = ld_en  ? ld_val  : q;
    set_bits = set_en ? set_val : '0;
    clr_bits = clr_en ? clr_val : '0;
    // Order: direct load, then clear, then set
    nxt      = (base & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/irq_pend_enc.sv
module irq_pend_enc #(
  parameter int unsigned N_EV  = 2,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N_EV-1:0]  pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |pend;
    idx = '0;
    // Walk downward so the lowest set bit is the last to write
    for (int i = int'(N_EV) - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IDX_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int unsigned N_EV    = evt_irq_pkg::DEF_N_EV,
  parameter int unsigned CMP_BIT = evt_irq_pkg::DEF_CMP_BIT,
  parameter int unsigned CAP_BIT = evt_irq_pkg::DEF_CAP_BIT,
  parameter int unsigned IDX_W   = evt_irq_pkg::code_width(N_EV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EV-1:0]  ev_pulse,
  input  logic             mask_wr,
  input  logic [N_EV-1:0]  mask_wdata,
  input  logic             mask_set_wr,
  input  logic [N_EV-1:0]  mask_set_data,
  input  logic             mask_clr_wr,
  input  logic [N_EV-1:0]  mask_clr_data,
  input  logic             isr_set_wr,
  input  logic [N_EV-1:0]  isr_set_data,
  input  logic             isr_clr_wr,
  input  logic [N_EV-1:0]  isr_clr_data,
  input  logic             cmp_wr,
  input  logic             cap_rd,
  output logic [N_EV-1:0]  raw_o,
  output logic [N_EV-1:0]  mask_o,
  output logic [N_EV-1:0]  masked_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] pend_idx_o
);

  logic [N_EV-1:0] sw_set_v;
  logic [N_EV-1:0] sw_clr_v;
  logic [N_EV-1:0] side_clr_v;

  assign sw_set_v = isr_set_wr ? isr_set_data : '0;
  assign sw_clr_v = isr_clr_wr ? isr_clr_data : '0;

  // Raw status: one cell per source; access side effects go to fixed bits
  for (genvar g = 0; g < N_EV; g++) begin : g_raw
    assign side_clr_v[g] = ((g == CMP_BIT) && cmp_wr) || ((g == CAP_BIT) && cap_rd);

    irq_raw_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_ev    (ev_pulse[g]),
      .sw_set   (sw_set_v[g]),
      .sw_clr   (sw_clr_v[g]),
      .side_clr (side_clr_v[g]),
      .q        (raw_o[g])
    );
  end

  irq_mask_reg #(
    .N_EV (N_EV)
  ) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (mask_wr),
    .ld_val  (mask_wdata),
    .set_en  (mask_set_wr),
    .set_val (mask_set_data),
    .clr_en  (mask_clr_wr),
    .clr_val (mask_clr_data),
    .q       (mask_o)
  );

  assign masked_o = raw_o & mask_o;

  irq_pend_enc #(
    .N_EV  (N_EV),
    .IDX_W (IDX_W)
  ) u_enc (
    .pend (masked_o),
    .any  (irq_o),
    .idx  (pend_idx_o)
  );

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned N_EV    = 2,
  parameter int unsigned CMP_BIT = 0,
  parameter int unsigned IDX_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EV-1:0]  ev_pulse,
  input logic             mask_wr,
  input logic             mask_set_wr,
  input logic [N_EV-1:0]  mask_set_data,
  input logic             mask_clr_wr,
  input logic             isr_set_wr,
  input logic [N_EV-1:0]  isr_set_data,
  input logic             isr_clr_wr,
  input logic [N_EV-1:0]  isr_clr_data,
  input logic             cmp_wr,
  input logic             cap_rd,
  input logic [N_EV-1:0]  raw_o,
  input logic [N_EV-1:0]  mask_o,
  input logic [N_EV-1:0]  masked_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] pend_idx_o
);

  logic [N_EV-1:0] any_set;
  logic            quiet;

  assign any_set = ev_pulse | (isr_set_wr ? isr_set_data : '0);
  assign quiet   = !(|ev_pulse) && !isr_set_wr && !isr_clr_wr && !cmp_wr && !cap_rd;

  // R2
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_pulse) |=> ((raw_o & $past(ev_pulse)) == $past(ev_pulse)));

  // R3
  p_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    isr_set_wr |=> ((raw_o & $past(isr_set_data)) == $past(isr_set_data)));

  // R4
  p_sw_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr_wr && ((isr_clr_data & any_set) == '0)) |=> ((raw_o & $past(isr_clr_data)) == '0));

  // R5
  p_cmp_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !any_set[CMP_BIT]) |=> !raw_o[CMP_BIT]);

  // R6
  p_irq_matches_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_idx_o != '0));

  // R8
  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_wr |=> ((mask_o & $past(mask_set_data)) == $past(mask_set_data)));

  // R10
  p_raw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(raw_o));

  // R10
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr && !mask_set_wr && !mask_clr_wr) |=> $stable(mask_o));

  // R6
  p_masked_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_o & ~mask_o) == '0);

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .N_EV    (N_EV),
  .CMP_BIT (CMP_BIT),
  .IDX_W   (IDX_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_pulse      (ev_pulse),
  .mask_wr       (mask_wr),
  .mask_set_wr   (mask_set_wr),
  .mask_set_data (mask_set_data),
  .mask_clr_wr   (mask_clr_wr),
  .isr_set_wr    (isr_set_wr),
  .isr_set_data  (isr_set_data),
  .isr_clr_wr    (isr_clr_wr),
  .isr_clr_data  (isr_clr_data),
  .cmp_wr        (cmp_wr),
  .cap_rd        (cap_rd),
  .raw_o         (raw_o),
  .mask_o        (mask_o),
  .masked_o      (masked_o),
  .irq_o         (irq_o),
  .pend_idx_o    (pend_idx_o)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 2;
  localparam int IW         = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ev_pulse;
  logic          mask_wr, mask_set_wr, mask_clr_wr;
  logic [N-1:0]  mask_wdata, mask_set_data, mask_clr_data;
  logic          isr_set_wr, isr_clr_wr;
  logic [N-1:0]  isr_set_data, isr_clr_data;
  logic          cmp_wr, cap_rd;
  logic [N-1:0]  raw_o, mask_o, masked_o;
  logic          irq_o;
  logic [IW-1:0] pend_idx_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [N-1:0] m_raw;
  logic [N-1:0] m_mask;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_pulse      (ev_pulse),
    .mask_wr       (mask_wr),
    .mask_wdata    (mask_wdata),
    .mask_set_wr   (mask_set_wr),
    .mask_set_data (mask_set_data),
    .mask_clr_wr   (mask_clr_wr),
    .mask_clr_data (mask_clr_data),
    .isr_set_wr    (isr_set_wr),
    .isr_set_data  (isr_set_data),
    .isr_clr_wr    (isr_clr_wr),
    .isr_clr_data  (isr_clr_data),
    .cmp_wr        (cmp_wr),
    .cap_rd        (cap_rd),
    .raw_o         (raw_o),
    .mask_o        (mask_o),
    .masked_o      (masked_o),
    .irq_o         (irq_o),
    .pend_idx_o    (pend_idx_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_pulse = '0;
    mask_wr = 1'b0; mask_wdata = '0;
    mask_set_wr = 1'b0; mask_set_data = '0;
    mask_clr_wr = 1'b0; mask_clr_data = '0;
    isr_set_wr = 1'b0; isr_set_data = '0;
    isr_clr_wr = 1'b0; isr_clr_data = '0;
    cmp_wr = 1'b0; cap_rd = 1'b0;
  endtask

  // Update the expected state from the driven strobes, then let one edge pass
  task automatic step();
    logic [N-1:0] clr_e, set_e, base;
    clr_e  = (isr_clr_wr ? isr_clr_data : '0) | {cap_rd, cmp_wr};
    set_e  = ev_pulse | (isr_set_wr ? isr_set_data : '0);
    m_raw  = (m_raw & ~clr_e) | set_e;
    base   = mask_wr ? mask_wdata : m_mask;
    m_mask = (base & ~(mask_clr_wr ? mask_clr_data : '0)) | (mask_set_wr ? mask_set_data : '0);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic logic [IW-1:0] exp_idx(input logic [N-1:0] m);
    if (m[0]) return 2'd1;
    if (m[1]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check_all(input string tag);
    logic [N-1:0] mk;
    mk = m_raw & m_mask;
    chk({tag, " raw"},  8'(raw_o),  8'(m_raw));
    chk({tag, " mask"}, 8'(mask_o), 8'(m_mask));
    chk({tag, " R6 masked"}, 8'(masked_o), 8'(mk));
    chk({tag, " R6 irq"}, 8'(irq_o), 8'(|mk));
    chk({tag, " R9 idx"}, 8'(pend_idx_o), 8'(exp_idx(mk)));
  endtask

  initial begin
    idle();
    rst_n  = 1'b0;
    m_raw  = '0;
    m_mask = '0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1 raw in reset", 8'(raw_o), 8'h0);
    chk("R1 irq in reset", 8'(irq_o), 8'h0);
    rst_n = 1'b1;
    check_all("R1 after reset");

    // R7: direct mask load
    mask_wr = 1'b1; mask_wdata = 2'b10; step();
    check_all("R7 load");
    // R3: set bit 0 while it is masked off, so irq stays low
    isr_set_wr = 1'b1; isr_set_data = 2'b01; step();
    chk("R3 set bit0", 8'(raw_o), 8'h1);
    chk("R6 masked off", 8'(irq_o), 8'h0);
    // R8: enable bit 0 -> code 1
    mask_set_wr = 1'b1; mask_set_data = 2'b01; step();
    chk("R8 mask set", 8'(mask_o), 8'h3);
    chk("R9 code one", 8'(pend_idx_o), 8'h1);
    // R9: both pending, bit 0 wins
    isr_set_wr = 1'b1; isr_set_data = 2'b10; step();
    chk("R9 priority", 8'(pend_idx_o), 8'h1);
    // R4: clear bit 0 -> code 2
    isr_clr_wr = 1'b1; isr_clr_data = 2'b01; step();
    chk("R4 clear", 8'(raw_o), 8'h2);
    chk("R9 code two", 8'(pend_idx_o), 8'h2);
    // R5: capture read clears bit 1 only
    isr_set_wr = 1'b1; isr_set_data = 2'b01; step();
    cap_rd = 1'b1; step();
    chk("R5 capture read", 8'(raw_o), 8'h1);
    // R2: event beats a compare write on the same bit
    ev_pulse = 2'b01; cmp_wr = 1'b1; step();
    chk("R2 event wins", 8'(raw_o), 8'h1);
    // R10: a quiet cycle keeps state
    step();
    check_all("R10 hold");

    // Raw path sweep: every strobe combination from every start state
    mask_wr = 1'b1; mask_wdata = 2'b11; step();
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 1024; c++) begin
        isr_clr_wr = 1'b1; isr_clr_data = 2'b11;
        isr_set_wr = 1'b1; isr_set_data = 2'(s);
        step();
        ev_pulse     = 2'(c);
        isr_set_wr   = c[2];
        isr_set_data = 2'(c >> 3);
        isr_clr_wr   = c[5];
        isr_clr_data = 2'(c >> 6);
        cmp_wr       = c[8];
        cap_rd       = c[9];
        step();
        check_all("R2 R3 R4 R5 R10 sweep");
      end
    end

    // Mask path sweep with both sources pending
    isr_set_wr = 1'b1; isr_set_data = 2'b11; step();
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 512; c++) begin
        mask_wr = 1'b1; mask_wdata = 2'(s);
        step();
        mask_wr       = c[0];
        mask_wdata    = 2'(c >> 1);
        mask_set_wr   = c[3];
        mask_set_data = 2'(c >> 4);
        mask_clr_wr   = c[6];
        mask_clr_data = 2'(c >> 7);
        step();
        check_all("R7 R8 R10 mask sweep");
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule